// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

A free-running system timer built around one shared up counter. A programmable prescaler divides the clock before it reaches the counter. Several compare channels watch that counter. Each channel raises its own interrupt line when the counter steps onto that channel's programmed value. The interrupt line stays high until software clears the channel's flag.

Software controls everything through a small word-addressed register port. Writes take effect at the clock edge where `wrEn` is high. Reads are combinational from `addr`.

Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | control: bit 0 run, bit 1 freeze-on-halt, bits 15:8 prescale |
| 1 | counter value |
| 2 | channel flags: bit i is channel i |
| 3 | channel enables: bit i is channel i |
| 4+i | compare value of channel i |

A debug-halt input can stop the count, so a halted processor sees a timer that is still consistent when it resumes.

Top module: `sys_cmp_timer`

## Requirements
- R1: The counter is 32 bits wide and only ever holds its value, steps up by exactly one, or takes a software-written value.
- R2: With prescale value N in control bits 15:8, the counter advances once every N+1 clocks while running.
- R3: While control bit 0 (run) is 0, the counter holds its value.
- R4: While control bit 1 (freeze) is 1 and `dbgHalt` is high, the counter holds. With freeze at 0, `dbgHalt` has no effect.
- R5: The counter steps from 0xFFFFFFFF to 0, and this wrap sets no flag.
- R6: A write to address 1 loads the counter and restarts the prescaler, so the first step comes N+1 clocks after the load.
- R7: The flag of channel i (address 2, bit i) is set when the counter steps onto that channel's compare value (address 4+i) while channel i is enabled (address 3, bit i). A direct counter write that lands on the compare value sets no flag. A disabled channel never sets its flag.
- R8: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: `irq[i]` is high exactly when flag i is set and channel i is enabled. Disabling a channel masks its interrupt without clearing its flag.
- R10: When a step onto the compare value and a clear of the same flag fall in one cycle, the flag ends set.
- R11: After reset, all registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgHalt | input | 1 | Debug halt request |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational from addr |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
Two functions can land on the same clock edge:
- a counter step that matches a compare value, and
- a software write-1-clear of that channel's flag.

The bench provokes this by loading the counter three steps below the compare value with no prescaling. It then times the clear write so that it lands on the matching edge. The result is judged by reading the flag register and `irq` afterwards: both must still show the event. A second clear on a later, quiet cycle must then remove it.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CNT  = 1;
  localparam int ADDR_FLAG = 2;
  localparam int ADDR_CHEN = 3;
  localparam int ADDR_CMP0 = 4;

  typedef struct packed {
    logic tick;
    logic cntLoad;
    logic flagClr;
  } strobe_t;
endpackage

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dbgHalt,
  input  logic                    wrEn,
  input  logic [AW-1:0]           addr,
  input  logic                    enIn,
  input  logic                    frzIn,
  input  logic [PW-1:0]           pscIn,
  input  logic [NCH-1:0]          chEnIn,
  input  logic [CW-1:0]           count,
  input  logic [NCH-1:0]          flags,
  input  logic [NCH-1:0][CW-1:0]  cmpVal,
  output logic                    enBit,
  output logic                    freezeBit,
  output logic [NCH-1:0]          chEn,
  output logic [NCH-1:0]          cmpSel,
  output strobe_t                 strb,
  output logic [CW-1:0]           rdData
);
  logic [31:0]   addrW;
  logic [PW-1:0] psc;
  logic [PW-1:0] psCnt;
  logic          running;
  logic          wrapNow;

  assign addrW   = 32'(addr);
  assign running = enBit && !(freezeBit && dbgHalt);
  assign wrapNow = (psCnt >= psc);

  always_comb begin
    strb         = '0;
    strb.cntLoad = wrEn && (addrW == ADDR_CNT);
    strb.flagClr = wrEn && (addrW == ADDR_FLAG);
    strb.tick    = running && wrapNow && !strb.cntLoad;
    for (int i = 0; i < NCH; i++) begin
      cmpSel[i] = wrEn && (addrW == ADDR_CMP0 + i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      freezeBit <= 1'b0;
      psc       <= '0;
      chEn      <= '0;
    end else if (wrEn) begin
      if (addrW == ADDR_CTRL) begin
        enBit     <= enIn;
        freezeBit <= frzIn;
        psc       <= pscIn;
      end
      if (addrW == ADDR_CHEN) chEn <= chEnIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              psCnt <= '0;
    else if (strb.cntLoad)  psCnt <= '0;
    else if (running)       psCnt <= wrapNow ? '0 : psCnt + PW'(1);
  end

  always_comb begin
    rdData = '0;
    case (addrW)
      ADDR_CTRL: begin
        rdData[0]      = enBit;
        rdData[1]      = freezeBit;
        rdData[8 +: PW] = psc;
      end
      ADDR_CNT:  rdData = count;
      ADDR_FLAG: rdData[NCH-1:0] = flags;
      ADDR_CHEN: rdData[NCH-1:0] = chEn;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addrW == ADDR_CMP0 + i) rdData = cmpVal[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_pkg::*;
#(
  parameter int CW  = 32,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [NCH-1:0]          cmpSel,
  input  logic [NCH-1:0]          chEn,
  input  logic [CW-1:0]           wrData,
  output logic [CW-1:0]           count,
  output logic [NCH-1:0]          flags,
  output logic [NCH-1:0][CW-1:0]  cmpVal,
  output logic [NCH-1:0]          irq
);
  logic [CW-1:0] countNext;

  assign countNext = count + CW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.cntLoad) count <= wrData;
    else if (strb.tick)    count <= countNext;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit;
    assign hit = strb.tick && chEn[i] && (countNext == cmpVal[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cmpVal[i] <= '0;
      else if (cmpSel[i]) cmpVal[i] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            flags[i] <= 1'b0;
      else if (hit)                         flags[i] <= 1'b1;
      else if (strb.flagClr && wrData[i])   flags[i] <= 1'b0;
    end

    assign irq[i] = flags[i] && chEn[i];
  end
endmodule

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer
  import sct_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dbgHalt,
  input  logic            wrEn,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wrData,
  output logic [CW-1:0]   rdData,
  output logic [NCH-1:0]  irq
);
  strobe_t                strb;
  logic                   enBit;
  logic                   freezeBit;
  logic [NCH-1:0]         chEn;
  logic [NCH-1:0]         cmpSel;
  logic [CW-1:0]          count;
  logic [NCH-1:0]         flags;
  logic [NCH-1:0][CW-1:0] cmpVal;

  sct_ctrl #(.CW(CW), .PW(PW), .NCH(NCH), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .wrEn(wrEn), .addr(addr),
    .enIn(wrData[0]), .frzIn(wrData[1]), .pscIn(wrData[8 +: PW]),
    .chEnIn(wrData[NCH-1:0]), .count(count), .flags(flags), .cmpVal(cmpVal),
    .enBit(enBit), .freezeBit(freezeBit), .chEn(chEn), .cmpSel(cmpSel),
    .strb(strb), .rdData(rdData)
  );

  sct_datapath #(.CW(CW), .NCH(NCH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpSel(cmpSel), .chEn(chEn),
    .wrData(wrData), .count(count), .flags(flags), .cmpVal(cmpVal), .irq(irq)
  );
endmodule

// File: rtl/sct_chk.sv
module sct_chk #(
  parameter int CW  = 32,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   dbgHalt,
  input logic                   enBit,
  input logic                   freezeBit,
  input logic                   cntLoad,
  input logic                   flagClr,
  input logic [NCH-1:0]         clrMask,
  input logic [CW-1:0]          count,
  input logic [NCH-1:0]         flags,
  input logic [NCH-1:0]         chEn,
  input logic [NCH-1:0][CW-1:0] cmpVal
);
  // R1: no change other than +1 unless loaded
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cntLoad |=> (count == $past(count) || count == $past(count) + CW'(1)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !cntLoad) |=> $stable(count));

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (freezeBit && dbgHalt && !cntLoad) |=> $stable(count));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (count == '1 && !cntLoad) |=> (count == '1 || count == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> (chEn[i] && count == cmpVal[i]));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !(flagClr && clrMask[i])) |=> flags[i]);
  end
endmodule

bind sys_cmp_timer sct_chk #(.CW(CW), .NCH(NCH)) chk_i (
  .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .enBit(enBit),
  .freezeBit(freezeBit), .cntLoad(strb.cntLoad), .flagClr(strb.flagClr),
  .clrMask(wrData[NCH-1:0]), .count(count), .flags(flags), .chEn(chEn),
  .cmpVal(cmpVal)
);

// File: tb/sys_cmp_timer_tb_top.sv
module sys_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgHalt = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sys_cmp_timer dut_i (
    .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input bit frz, input logic [7:0] n);
    return {16'h0, n, 6'h0, frz, en};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R11 reset register", v, 32'h0);
    end
    chk("R11 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(3'd0, ctrlWord(1, 0, 8'd3));
    step(2);
    wr(3'd1, 32'd100);
    step(8);  rd(3'd1, v); chk("R2 two periods of N=3", v, 32'd102);
    step(3);  rd(3'd1, v); chk("R2 mid period hold", v, 32'd102);
    step(1);  rd(3'd1, v); chk("R1 R2 next step", v, 32'd103);
    rd(3'd0, v); chk("R2 control readback", v, ctrlWord(1, 0, 8'd3));
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(3'd0, ctrlWord(1, 0, 8'd3));
    wr(3'd1, 32'd0);
    step(2);
    wr(3'd1, 32'd50);
    step(3); rd(3'd1, v); chk("R6 no step before N+1 after load", v, 32'd50);
    step(1); rd(3'd1, v); chk("R6 step at N+1 after load", v, 32'd51);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(3'd0, ctrlWord(0, 0, 8'd0));
    wr(3'd1, 32'd7);
    step(4); rd(3'd1, v); chk("R3 run off holds", v, 32'd7);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(3'd0, ctrlWord(1, 1, 8'd0));
    dbgHalt = 1'b1;
    wr(3'd1, 32'd10);
    step(5); rd(3'd1, v); chk("R4 frozen under halt", v, 32'd10);
    dbgHalt = 1'b0;
    step(3); rd(3'd1, v); chk("R4 resumes after halt", v, 32'd13);
    wr(3'd0, ctrlWord(1, 0, 8'd0));
    dbgHalt = 1'b1;
    step(2); rd(3'd1, v); chk("R4 halt ignored when freeze off", v, 32'd16);
    dbgHalt = 1'b0;
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(3'd2, 32'hF);
    wr(3'd4, 32'd3);
    wr(3'd3, 32'h1);
    wr(3'd0, ctrlWord(1, 0, 8'd0));
    wr(3'd1, 32'hFFFF_FFFE);
    step(1); rd(3'd1, v); chk("R5 reaches all ones", v, 32'hFFFF_FFFF);
    step(1); rd(3'd1, v); chk("R5 wraps to zero", v, 32'h0);
    rd(3'd2, v); chk("R5 no flag on wrap", v, 32'h0);
    step(3); rd(3'd2, v); chk("R7 match after wrap sets flag", v, 32'h1);
    chk("R9 irq for enabled flag", 32'(irq), 32'h1);
    wr(3'd2, 32'h1);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    wr(3'd0, ctrlWord(0, 0, 8'd0));
    wr(3'd2, 32'hF);
    wr(3'd6, 32'd110);
    wr(3'd5, 32'd108);
    wr(3'd7, 32'd107);
    wr(3'd3, 32'h6);
    wr(3'd1, 32'd110);
    rd(3'd2, v); chk("R7 load onto compare sets nothing", v, 32'h0);
    wr(3'd1, 32'd105);
    wr(3'd0, ctrlWord(1, 0, 8'd0));
    step(5); rd(3'd1, v); chk("R1 count at 110", v, 32'd110);
    rd(3'd2, v); chk("R7 channels 1 and 2 set, 3 disabled", v, 32'h6);
    chk("R9 irq lines", 32'(irq), 32'h6);
    step(4); rd(3'd2, v); chk("R8 flags stay set", v, 32'h6);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R8 zero write no effect", v, 32'h6);
    wr(3'd3, 32'h4);
    rd(3'd2, v); chk("R9 disable keeps flag", v, 32'h6);
    chk("R9 disable masks irq", 32'(irq), 32'h4);
    wr(3'd3, 32'h6);
    chk("R9 re-enable restores irq", 32'(irq), 32'h6);
    wr(3'd2, 32'h4);
    rd(3'd2, v); chk("R8 write-1 clears only its bit", v, 32'h2);
    wr(3'd2, 32'h2);
    chk("R8 irq drops after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(3'd0, ctrlWord(0, 0, 8'd0));
    wr(3'd2, 32'hF);
    wr(3'd4, 32'd203);
    wr(3'd3, 32'h1);
    wr(3'd0, ctrlWord(1, 0, 8'd0));
    wr(3'd1, 32'd200);
    step(2);
    wr(3'd2, 32'h1);
    rd(3'd1, v); chk("R10 count at compare", v, 32'd203);
    rd(3'd2, v); chk("R10 set wins over clear", v, 32'h1);
    chk("R10 irq held", 32'(irq), 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R10 later clear works", v, 32'h0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_prescale();
    t_restart();
    t_disabled();
    t_freeze();
    t_wrap();
    t_compare();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule